// File: doc/BRIEF.md
# Asynchronous Host Register Port

This block lets an external microprocessor read and write a handful of internal registers over a byte-wide bus that runs without any shared clock. The host pulls an active-low select line low and presents a read/write direction bit, a two-bit register address, a DMA-routing bit and a data byte. The block passes all of these through synchronizer flops into the system clock. It does not act on a select that lasts less than two sampled clocks. It answers on a three-state, active-low ready line, which is the four-phase acknowledge: ready is driven high as soon as select falls, goes low once the access has been carried out, and is driven high for one more cycle after select rises before it floats.

The register set holds an interrupt status register whose bits are set by internal event pulses and cleared when the host writes ones to them. It also holds an interrupt enable register and two configuration bytes that appear on output ports. An active-low interrupt output reports when any enabled status bit is set. A busy input from internal logic, for example a configuration load still in progress, holds the handshake in its waiting state for as long as it stays high. An access with the DMA bit set bypasses the registers: a write produces a one-cycle strobe with the byte, and a read returns the byte on the DMA read-data input.

Top module: `host_reg_port`

## Requirements
- R1: While reset is high and afterwards until the first access, the ready enable and data enable are 0, the interrupt output is 1, and both configuration outputs are 0x00.
- R2: The ready line is not driven (ready enable 0) while select is high and no handshake is finishing. It is driven high (enable 1, value 1) from the moment select is low until the access completes.
- R3: With select held low and busy low, ready goes low on the fifth rising clock edge after select falls: two synchronizer edges, then the capture, wait and ready states. It is never low unless select was sampled low on each of the two preceding edges.
- R4: A select low pulse of one clock period starts no transfer. Ready never goes low and no register changes.
- R5: Ready stays low while select is held low. After select rises, ready is driven high on the third rising edge and floats from the fourth.
- R6: The read/write bit is 1 for a read and 0 for a write. Register addresses are 0 = interrupt status, 1 = interrupt enable, 2 = configuration A, 3 = configuration B. Write data appears on the configuration output on the same edge that ready goes low.
- R7: The interrupt output is low exactly when (status AND enable) is nonzero. After a write to status or enable, it takes its new value one clock after ready goes low.
- R8: A high bit on the event input sets that status bit. Writing a 1 to a status bit clears it. When a set and a clear of the same bit happen in the same cycle, the bit ends up set.
- R9: On a read, the data bus is driven with the addressed value while ready is low and select is low. It stops being driven as soon as select rises.
- R10: While busy is high, ready stays driven high for any length of time. Ready goes low on the first rising edge at which busy is sampled low.
- R11: With the DMA bit set, no register is touched. A write gives a one-clock strobe with the write flag and the data byte, starting on the edge where ready goes low. A read returns the DMA read-data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hp_sel_n | input | 1 | Host select, active low, asynchronous |
| hp_rd_wr_n | input | 1 | 1 = read, 0 = write |
| hp_addr | input | 2 | Register address |
| hp_dma | input | 1 | Route access to the DMA interface |
| hp_data_i | input | 8 | Host write data |
| hp_data_o | output | 8 | Host read data |
| hp_data_oe | output | 1 | Drive enable for host read data |
| hp_rdy_n_o | output | 1 | Ready value, active low |
| hp_rdy_oe | output | 1 | Drive enable for ready |
| irq_n_o | output | 1 | Interrupt, active low |
| busy_i | input | 1 | Internal operation in progress, holds off completion |
| irq_src_i | input | 8 | Event pulses that set status bits |
| cfg_a_o | output | 8 | Configuration register A |
| cfg_b_o | output | 8 | Configuration register B |
| dma_stb_o | output | 1 | One-cycle DMA access strobe |
| dma_we_o | output | 1 | DMA access is a write |
| dma_wdata_o | output | 8 | DMA write byte |
| dma_rdata_i | input | 8 | DMA read byte |

## Verification
Every result has a fixed delay from the host edge that causes it. The bench drives inputs on falling clock edges and counts falling edges from that point. Ready completion is due after the fifth rising edge, so it is checked at the fifth falling edge, and the bench also confirms that ready is still high at the fourth. Configuration outputs and read data are checked at that same fifth sample. The interrupt is checked one sample later, and release and float are checked at the third and fourth samples after select rises. The ready enable and data enable follow the select pin without a register, so the bench checks them one nanosecond after it moves select.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CAPTURE = 3'd1,
        ST_WAIT    = 3'd2,
        ST_READY   = 3'd3,
        ST_RELEASE = 3'd4
    } hs_state_e;

    localparam logic [ADDR_W-1:0] REG_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] REG_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] REG_CFG_A  = 2'd2;
    localparam logic [ADDR_W-1:0] REG_CFG_B  = 2'd3;

    typedef struct packed {
        logic              rd;
        logic              dma;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } host_req_t;

    localparam int REQ_W = $bits(host_req_t);

    function automatic logic irq_pending(input logic [DATA_W-1:0] st,
                                         input logic [DATA_W-1:0] en);
        return |(st & en);
    endfunction

    // clear-by-one, with a new event taking priority over the clear
    function automatic logic [DATA_W-1:0] status_next(input logic [DATA_W-1:0] st,
                                                      input logic [DATA_W-1:0] clr,
                                                      input logic [DATA_W-1:0] set);
        return (st & ~clr) | set;
    endfunction

endpackage

// File: rtl/hrp_sync.sv
module hrp_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= {STAGES{RST_VAL}};
        end else begin
            stg_q <= {stg_q[STAGES-2:0], d};
        end
    end

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hrp_fsm.sv
module hrp_fsm
    import hrp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel_s,
    input  host_req_t req_s,
    input  logic      busy_i,
    output hs_state_e state_o,
    output host_req_t req_q,
    output logic      commit_o
);

    hs_state_e st_q;
    hs_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (sel_s) st_d = ST_CAPTURE;
            ST_CAPTURE: st_d = sel_s ? ST_WAIT : ST_IDLE;
            ST_WAIT: begin
                if (!sel_s)       st_d = ST_IDLE;
                else if (!busy_i) st_d = ST_READY;
            end
            ST_READY:   if (!sel_s) st_d = ST_RELEASE;
            ST_RELEASE: st_d = ST_IDLE;
            default:    st_d = ST_IDLE;
        endcase
    end

    assign commit_o = (st_q == ST_WAIT) && sel_s && !busy_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            req_q <= '0;
        end else begin
            st_q <= st_d;
            if (sel_s && (st_q == ST_IDLE || st_q == ST_CAPTURE)) begin
                req_q <= req_s;
            end
        end
    end

    assign state_o = st_q;

endmodule

// File: rtl/hrp_regs.sv
module hrp_regs
    import hrp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  host_req_t         req,
    input  logic [DATA_W-1:0] irq_src_i,
    input  logic [DATA_W-1:0] dma_rdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] cfg_a_o,
    output logic [DATA_W-1:0] cfg_b_o,
    output logic              irq_n_o,
    output logic              dma_stb_o,
    output logic              dma_we_o,
    output logic [DATA_W-1:0] dma_wdata_o
);

    logic [DATA_W-1:0] stat_q, en_q, cfg_a_q, cfg_b_q, rdata_q, dma_wdata_q;
    logic              irq_n_q, dma_stb_q, dma_we_q;
    logic              host_wr;
    logic [DATA_W-1:0] clr_mask;
    logic [DATA_W-1:0] reg_rd;

    assign host_wr  = commit && !req.rd && !req.dma;
    assign clr_mask = (host_wr && req.addr == REG_STATUS) ? req.data : '0;

    always_comb begin
        unique case (req.addr)
            REG_STATUS: reg_rd = stat_q;
            REG_ENABLE: reg_rd = en_q;
            REG_CFG_A:  reg_rd = cfg_a_q;
            default:    reg_rd = cfg_b_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q      <= '0;
            en_q        <= '0;
            cfg_a_q     <= '0;
            cfg_b_q     <= '0;
            rdata_q     <= '0;
            irq_n_q     <= 1'b1;
            dma_stb_q   <= 1'b0;
            dma_we_q    <= 1'b0;
            dma_wdata_q <= '0;
        end else begin
            stat_q  <= status_next(stat_q, clr_mask, irq_src_i);
            irq_n_q <= !irq_pending(stat_q, en_q);
            if (host_wr && req.addr == REG_ENABLE) en_q    <= req.data;
            if (host_wr && req.addr == REG_CFG_A)  cfg_a_q <= req.data;
            if (host_wr && req.addr == REG_CFG_B)  cfg_b_q <= req.data;
            if (commit) rdata_q <= req.dma ? dma_rdata_i : reg_rd;
            dma_stb_q <= commit && req.dma;
            if (commit && req.dma) begin
                dma_we_q    <= !req.rd;
                dma_wdata_q <= req.data;
            end
        end
    end

    assign rdata_o     = rdata_q;
    assign cfg_a_o     = cfg_a_q;
    assign cfg_b_o     = cfg_b_q;
    assign irq_n_o     = irq_n_q;
    assign dma_stb_o   = dma_stb_q;
    assign dma_we_o    = dma_we_q;
    assign dma_wdata_o = dma_wdata_q;

endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
    import hrp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hp_sel_n,
    input  logic              hp_rd_wr_n,
    input  logic [ADDR_W-1:0] hp_addr,
    input  logic              hp_dma,
    input  logic [DATA_W-1:0] hp_data_i,
    output logic [DATA_W-1:0] hp_data_o,
    output logic              hp_data_oe,
    output logic              hp_rdy_n_o,
    output logic              hp_rdy_oe,
    output logic              irq_n_o,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] irq_src_i,
    output logic [DATA_W-1:0] cfg_a_o,
    output logic [DATA_W-1:0] cfg_b_o,
    output logic              dma_stb_o,
    output logic              dma_we_o,
    output logic [DATA_W-1:0] dma_wdata_o,
    input  logic [DATA_W-1:0] dma_rdata_i
);

    logic             sel_n_s;
    logic [REQ_W-1:0] req_raw;
    logic [REQ_W-1:0] req_sync;
    host_req_t        req_s;
    host_req_t        req_q;
    hs_state_e        state;
    logic             commit;
    logic [DATA_W-1:0] rdata;

    assign req_raw = {hp_rd_wr_n, hp_dma, hp_addr, hp_data_i};

    hrp_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sel_sync (
        .clk (clk),
        .rst (rst),
        .d   (hp_sel_n),
        .q   (sel_n_s)
    );

    hrp_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_raw),
        .q   (req_sync)
    );

    assign req_s = host_req_t'(req_sync);

    hrp_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sel_s    (!sel_n_s),
        .req_s    (req_s),
        .busy_i   (busy_i),
        .state_o  (state),
        .req_q    (req_q),
        .commit_o (commit)
    );

    hrp_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .req         (req_q),
        .irq_src_i   (irq_src_i),
        .dma_rdata_i (dma_rdata_i),
        .rdata_o     (rdata),
        .cfg_a_o     (cfg_a_o),
        .cfg_b_o     (cfg_b_o),
        .irq_n_o     (irq_n_o),
        .dma_stb_o   (dma_stb_o),
        .dma_we_o    (dma_we_o),
        .dma_wdata_o (dma_wdata_o)
    );

    // pad-side drive: ready is enabled straight from the select pin
    assign hp_rdy_oe  = !hp_sel_n || state == ST_READY || state == ST_RELEASE;
    assign hp_rdy_n_o = (state != ST_READY);
    assign hp_data_oe = (state == ST_READY) && !hp_sel_n && req_q.rd;
    assign hp_data_o  = rdata;

endmodule

// File: rtl/hrp_checker.sv
module hrp_checker (
    input logic clk,
    input logic rst,
    input logic hp_sel_n,
    input logic hp_rdy_n_o,
    input logic hp_rdy_oe,
    input logic hp_data_oe,
    input logic busy_i,
    input logic dma_stb_o
);

    logic rdy_act;
    assign rdy_act = hp_rdy_oe && !hp_rdy_n_o;

    p_rdy_late_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_act) |-> ($past(!hp_sel_n) && $past(!hp_sel_n, 2)));

    p_rdy_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (rdy_act && !hp_sel_n) |=> rdy_act);

    p_release_high_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_act) |-> (hp_rdy_oe && hp_rdy_n_o));

    p_busy_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(rdy_act) |-> !$past(busy_i));

    p_data_in_ready_r9: assert property (@(posedge clk) disable iff (rst)
        hp_data_oe |-> rdy_act);

    p_dma_single_r11: assert property (@(posedge clk) disable iff (rst)
        dma_stb_o |=> !dma_stb_o);

endmodule

bind host_reg_port hrp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .hp_sel_n   (hp_sel_n),
    .hp_rdy_n_o (hp_rdy_n_o),
    .hp_rdy_oe  (hp_rdy_oe),
    .hp_data_oe (hp_data_oe),
    .busy_i     (busy_i),
    .dma_stb_o  (dma_stb_o)
);

// File: tb/host_reg_port_tb.sv
`timescale 1ns/1ps
module host_reg_port_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hp_sel_n = 1'b1;
    logic       hp_rd_wr_n = 1'b1;
    logic [1:0] hp_addr = '0;
    logic       hp_dma = 1'b0;
    logic [7:0] hp_data_i = '0;
    logic [7:0] hp_data_o;
    logic       hp_data_oe, hp_rdy_n_o, hp_rdy_oe, irq_n_o;
    logic       busy_i = 1'b0;
    logic [7:0] irq_src_i = '0;
    logic [7:0] cfg_a_o, cfg_b_o, dma_wdata_o;
    logic       dma_stb_o, dma_we_o;
    logic [7:0] dma_rdata_i = 8'hC3;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;
    int dma_cnt = 0;
    logic       dma_we_seen = 1'b0;
    logic [7:0] dma_data_seen = '0;

    always #4 clk = ~clk;

    host_reg_port u_dut (
        .clk(clk), .rst(rst), .hp_sel_n(hp_sel_n), .hp_rd_wr_n(hp_rd_wr_n),
        .hp_addr(hp_addr), .hp_dma(hp_dma), .hp_data_i(hp_data_i),
        .hp_data_o(hp_data_o), .hp_data_oe(hp_data_oe), .hp_rdy_n_o(hp_rdy_n_o),
        .hp_rdy_oe(hp_rdy_oe), .irq_n_o(irq_n_o), .busy_i(busy_i),
        .irq_src_i(irq_src_i), .cfg_a_o(cfg_a_o), .cfg_b_o(cfg_b_o),
        .dma_stb_o(dma_stb_o), .dma_we_o(dma_we_o), .dma_wdata_o(dma_wdata_o),
        .dma_rdata_i(dma_rdata_i)
    );

    always @(posedge clk) begin
        if (dma_stb_o) begin
            dma_cnt++;
            dma_we_seen   = dma_we_o;
            dma_data_seen = dma_wdata_o;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // vector fields: [19] rd, [18] dma, [17:16] addr, [15:8] wdata, [7:0] expected
    localparam int NVEC = 10;
    localparam logic [19:0] VEC [NVEC] = '{
        20'h2A5A5, 20'h33C3C, 20'hA00A5, 20'hB003C, 20'h10F0F,
        20'h9000F, 20'h80000, 20'h67777, 20'hC00C3, 20'hA00A5
    };

    task automatic begin_xfer(input logic rd, input logic dma, input logic [1:0] addr,
                              input logic [7:0] data);
        hp_rd_wr_n = rd;
        hp_dma     = dma;
        hp_addr    = addr;
        hp_data_i  = data;
        hp_sel_n   = 1'b0;
        #1;
        chk(hp_rdy_oe && hp_rdy_n_o, "R2 ready driven high on select", {hp_rdy_oe, hp_rdy_n_o}, 2'b11);
        repeat (4) @(negedge clk);
        chk(hp_rdy_oe && hp_rdy_n_o, "R3 ready still high at edge 4", {hp_rdy_oe, hp_rdy_n_o}, 2'b11);
        @(negedge clk);
        chk(hp_rdy_oe && !hp_rdy_n_o, "R3 ready low at edge 5", {hp_rdy_oe, hp_rdy_n_o}, 2'b10);
    endtask

    task automatic end_xfer();
        hp_sel_n = 1'b1;
        #1;
        chk(!hp_data_oe, "R9 data floats on select rise", hp_data_oe, 0);
        repeat (2) @(negedge clk);
        chk(hp_rdy_oe && !hp_rdy_n_o, "R5 ready held low before release", {hp_rdy_oe, hp_rdy_n_o}, 2'b10);
        @(negedge clk);
        chk(hp_rdy_oe && hp_rdy_n_o, "R5 ready driven high on release", {hp_rdy_oe, hp_rdy_n_o}, 2'b11);
        @(negedge clk);
        chk(!hp_rdy_oe, "R5 ready floats after release", hp_rdy_oe, 0);
    endtask

    task automatic read_reg(input logic [1:0] addr, input logic [7:0] exp, input string tag);
        begin_xfer(1'b1, 1'b0, addr, 8'h00);
        chk(hp_data_oe && hp_data_o == exp, tag, hp_data_o, exp);
        end_xfer();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!hp_rdy_oe && !hp_data_oe && irq_n_o, "R1 outputs during reset",
            {hp_rdy_oe, hp_data_oe, irq_n_o}, 3'b001);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(!hp_rdy_oe && !hp_data_oe && irq_n_o && cfg_a_o == 0 && cfg_b_o == 0,
            "R1 idle state after reset", {hp_rdy_oe, hp_data_oe, irq_n_o, cfg_a_o, cfg_b_o},
            {3'b001, 16'h0});
        chk(!hp_rdy_oe, "R2 ready floats while unselected", hp_rdy_oe, 0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            automatic logic [19:0] v = VEC[i];
            automatic int cnt0 = dma_cnt;
            begin_xfer(v[19], v[18], v[17:16], v[15:8]);
            if (v[19]) begin
                chk(hp_data_oe && hp_data_o == v[7:0], v[18] ? "R11 dma read data" : "R9 read data",
                    hp_data_o, v[7:0]);
            end else if (!v[18] && v[17:16] == 2'd2) begin
                chk(cfg_a_o == v[7:0], "R6 cfg A written", cfg_a_o, v[7:0]);
            end else if (!v[18] && v[17:16] == 2'd3) begin
                chk(cfg_b_o == v[7:0], "R6 cfg B written", cfg_b_o, v[7:0]);
            end
            end_xfer();
            if (v[18]) begin
                chk(dma_cnt == cnt0 + 1 && dma_we_seen == !v[19], "R11 one dma strobe",
                    dma_cnt - cnt0, 1);
                if (!v[19]) chk(dma_data_seen == v[7:0], "R11 dma write byte", dma_data_seen, v[7:0]);
            end else begin
                chk(dma_cnt == cnt0, "R11 no dma strobe for register access", dma_cnt - cnt0, 0);
            end
        end
        chk(cfg_a_o == 8'hA5 && cfg_b_o == 8'h3C, "R11 dma left registers", {cfg_a_o, cfg_b_o}, 16'hA53C);

        // interrupt: enable is 0x0F; event on bit 1
        chk(irq_n_o, "R7 no interrupt yet", irq_n_o, 1);
        irq_src_i = 8'h02;
        @(negedge clk);
        irq_src_i = 8'h00;
        @(negedge clk);
        chk(!irq_n_o, "R7 interrupt asserted", irq_n_o, 0);
        begin_xfer(1'b0, 1'b0, 2'd0, 8'h02);
        chk(!irq_n_o, "R7 interrupt still low at ready", irq_n_o, 0);
        @(negedge clk);
        chk(irq_n_o, "R7 interrupt cleared one clock after ready", irq_n_o, 1);
        end_xfer();
        read_reg(2'd0, 8'h00, "R8 status cleared by write one");

        // masked event, then set wins over clear
        irq_src_i = 8'h20;
        repeat (3) @(negedge clk);
        chk(irq_n_o, "R7 masked bit gives no interrupt", irq_n_o, 1);
        begin_xfer(1'b0, 1'b0, 2'd0, 8'h20);
        end_xfer();
        irq_src_i = 8'h00;
        @(negedge clk);
        read_reg(2'd0, 8'h20, "R8 set wins over clear");
        begin_xfer(1'b0, 1'b0, 2'd0, 8'h20);
        end_xfer();
        read_reg(2'd0, 8'h00, "R8 status bit cleared");
        begin_xfer(1'b0, 1'b0, 2'd1, 8'h20);
        end_xfer();
        irq_src_i = 8'h20;
        @(negedge clk);
        irq_src_i = 8'h00;
        @(negedge clk);
        chk(!irq_n_o, "R7 newly enabled bit interrupts", irq_n_o, 0);

        // busy hold-off
        busy_i = 1'b1;
        hp_rd_wr_n = 1'b0; hp_dma = 1'b0; hp_addr = 2'd3; hp_data_i = 8'h5A;
        hp_sel_n = 1'b0;
        repeat (40) @(negedge clk);
        chk(hp_rdy_oe && hp_rdy_n_o, "R10 ready held high while busy", {hp_rdy_oe, hp_rdy_n_o}, 2'b11);
        chk(cfg_b_o == 8'h3C, "R10 no write while busy", cfg_b_o, 8'h3C);
        busy_i = 1'b0;
        @(negedge clk);
        chk(hp_rdy_oe && !hp_rdy_n_o, "R10 ready low after busy drops", {hp_rdy_oe, hp_rdy_n_o}, 2'b10);
        chk(cfg_b_o == 8'h5A, "R10 write lands after busy", cfg_b_o, 8'h5A);
        end_xfer();

        // one-period select glitch
        hp_rd_wr_n = 1'b0; hp_dma = 1'b0; hp_addr = 2'd2; hp_data_i = 8'hFF;
        hp_sel_n = 1'b0;
        @(negedge clk);
        hp_sel_n = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!(hp_rdy_oe && !hp_rdy_n_o), "R4 no ready on short select", hp_rdy_n_o, 1);
        end
        chk(cfg_a_o == 8'hA5, "R4 short select changes nothing", cfg_a_o, 8'hA5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL R10 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule